// File: doc/BRIEF.md
# Audio Bus Master Clock Generator

This block produces the two timing lines of a serial audio bus: the bit clock, which paces each data bit, and the word clock, which marks where a frame begins. When the port is the bus master, the bit clock comes from the system clock through a programmable integer divider. A frame counter then counts a programmable number of bit clocks per frame. The word clock is shaped either as a one-bit-clock pulse or as a square wave with a 50% duty cycle. The frame length can be set to match the word length, or made longer so that several devices can take turns on one bus.

Each of the two lines is set to master or slave on its own. In master mode the line is driven and its output enable is high. In slave mode the line is taken from its input pin through a synchronizer, and its output enable stays low. In both modes the block gives the data port one-system-clock strobes for bit-clock rising edges, bit-clock falling edges and frame starts. All configuration is held in shadow registers, which load only at a frame boundary. Taking the power enable low forces a reset and releases both lines.

Top module: `audio_clkgen`

## Requirements
- R1: While `rst` is high, or in the cycle after `pwr_en` has been sampled low, the outputs `bclk_oe`, `wclk_oe`, `bclk_out`, `wclk_out`, `bclk_rise`, `bclk_fall` and `frame_start` are all 0.
- R2: In bit-clock master mode with divider value D, `bclk_out` has a period of D system clocks and is high for floor(D/2) of them. The first rising edge appears at the first clock edge after power-up.
- R3: A divider value of 0 or 1 behaves as 2.
- R4: `bclk_rise` is high for exactly the one cycle in which `bclk_out` has just gone from 0 to 1. `bclk_fall` does the same for a change from 1 to 0. The two strobes are never high together.
- R5: With word-clock master mode and frame length L, a frame is L bit clocks long. `frame_start` is high in the same cycle as the `bclk_rise` that opens each frame, and the first rise after power-up opens a frame. A length of 0 or 1 behaves as 2.
- R6: When `cfg_wc_square` = 1, `wclk_out` is high during bit clocks 0 to floor(L/2)-1 of each frame and low for the rest of the frame.
- R7: When `cfg_wc_square` = 0, `wclk_out` is high during bit clock 0 of each frame only.
- R8: `bclk_oe` equals `cfg_bclk_master` and `wclk_oe` equals `cfg_wclk_master`. In bit-clock slave mode, `bclk_out` repeats `bclk_in` three system clocks later. The rise and fall strobes then follow edges of the input, and word-clock master mode counts those input rises.
- R9: In word-clock slave mode, `wclk_out` repeats `wclk_in` three system clocks later. `frame_start` marks each synchronized rising edge of `wclk_in`.
- R10: A change of divider, length or shape made in the middle of a frame does not affect that frame. The new values govern from the frame-start edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_en | input | 1 | Interface power enable; low holds the block in reset and releases the lines |
| cfg_div | input | DIV_W | Bit-clock divider (system clocks per bit clock) |
| cfg_frame_len | input | LEN_W | Bit clocks per frame |
| cfg_wc_square | input | 1 | Word-clock shape: 1 = square wave, 0 = pulse |
| cfg_bclk_master | input | 1 | 1 = drive the bit clock, 0 = take it from `bclk_in` |
| cfg_wclk_master | input | 1 | 1 = drive the word clock, 0 = take it from `wclk_in` |
| bclk_in | input | 1 | Bit clock from the bus in slave mode |
| wclk_in | input | 1 | Word clock from the bus in slave mode |
| bclk_out | output | 1 | Bit clock value |
| bclk_oe | output | 1 | Output enable for the bit-clock pad |
| wclk_out | output | 1 | Word clock value |
| wclk_oe | output | 1 | Output enable for the word-clock pad |
| bclk_rise | output | 1 | One-cycle strobe on a bit-clock rising edge |
| bclk_fall | output | 1 | One-cycle strobe on a bit-clock falling edge |
| frame_start | output | 1 | One-cycle strobe at the start of a frame |

## Verification
Two events can fall on the same clock edge: the shadow-register load and the bit-clock rise that closes a frame. At that edge, the old divider finishes its count while the new divider must take over for the very next half period. The bench provokes this by writing a new divider, length and shape in the middle of a square-wave frame. It then predicts each later cycle with the old settings up to that boundary and with the new settings after it, so a load that comes one edge early or one edge late shows up as a wrong bit-clock phase. The same edge also carries `bclk_rise` and `frame_start` together, and the bench checks both strobes against a cycle-count model in every run.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;
  typedef enum logic {
    WC_PULSE  = 1'b0,
    WC_SQUARE = 1'b1
  } wc_shape_e;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/acg_sync.sv
module acg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise_nx,
  output logic fall_nx
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign level   = sh[STAGES-1];
  assign rise_nx =  sh[STAGES-1] & ~sh[STAGES];
  assign fall_nx = ~sh[STAGES-1] &  sh[STAGES];
endmodule

// File: rtl/acg_bclk_gen.sv
module acg_bclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             master,
  input  logic [DIV_W-1:0] div,
  input  logic             sl_rise,
  input  logic             sl_fall,
  output logic             rise_nx,
  output logic             bclk_q,
  output logic             rise_q,
  output logic             fall_q
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt, cnt_nx, half;
  logic             fall_nx;

  assign half   = div >> 1;
  assign cnt_nx = (cnt >= div - ONE) ? '0 : cnt + ONE;

  always_comb begin
    if (master) begin
      rise_nx = (cnt_nx == '0);
      fall_nx = (cnt_nx == half);
    end else begin
      rise_nx = sl_rise;
      fall_nx = sl_fall;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '1;
      bclk_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      cnt    <= cnt_nx;
      rise_q <= rise_nx;
      fall_q <= fall_nx;
      if (rise_nx)      bclk_q <= 1'b1;
      else if (fall_nx) bclk_q <= 1'b0;
    end
  end
endmodule

// File: rtl/acg_frame_gen.sv
module acg_frame_gen
  import audio_clkgen_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             master,
  input  wc_shape_e        shape,
  input  logic [LEN_W-1:0] len,
  input  logic             rise_nx,
  input  logic             sl_level,
  input  logic             sl_rise,
  output logic             frame_nx,
  output logic             wclk_q,
  output logic             fs_q
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] bidx, bidx_nx, half;

  assign half    = len >> 1;
  assign bidx_nx = (bidx >= len - ONE) ? '0 : bidx + ONE;
  assign frame_nx = master ? (rise_nx && (bidx_nx == '0)) : sl_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      bidx   <= '1;
      wclk_q <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      fs_q <= frame_nx;
      if (master) begin
        if (rise_nx) begin
          bidx   <= bidx_nx;
          wclk_q <= (shape == WC_SQUARE) ? (bidx_nx < half) : (bidx_nx == '0);
        end
      end else begin
        bidx   <= '1;
        wclk_q <= sl_level;
      end
    end
  end
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import audio_clkgen_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_en,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [LEN_W-1:0] cfg_frame_len,
  input  logic             cfg_wc_square,
  input  logic             cfg_bclk_master,
  input  logic             cfg_wclk_master,
  input  logic             bclk_in,
  input  logic             wclk_in,
  output logic             bclk_out,
  output logic             bclk_oe,
  output logic             wclk_out,
  output logic             wclk_oe,
  output logic             bclk_rise,
  output logic             bclk_fall,
  output logic             frame_start
);
  localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);
  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(2);

  logic             run_rst;
  logic [DIV_W-1:0] div_c, act_div;
  logic [LEN_W-1:0] len_c, act_len;
  logic             act_sq, act_bm, act_wm;
  logic             b_lvl, b_rise, b_fall;
  logic             w_lvl, w_rise, w_fall;
  logic             rise_nx, frame_nx;
  logic             bclk_oe_q, wclk_oe_q;

  assign run_rst = rst | ~pwr_en;
  assign div_c   = (cfg_div < DIV_MIN) ? DIV_MIN : cfg_div;
  assign len_c   = (cfg_frame_len < LEN_MIN) ? LEN_MIN : cfg_frame_len;

  // shadow configuration: loads in reset and at each frame boundary
  always_ff @(posedge clk) begin
    if (run_rst || frame_nx) begin
      act_div <= div_c;
      act_len <= len_c;
      act_sq  <= cfg_wc_square;
      act_bm  <= cfg_bclk_master;
      act_wm  <= cfg_wclk_master;
    end
  end

  always_ff @(posedge clk) begin
    if (run_rst) begin
      bclk_oe_q <= 1'b0;
      wclk_oe_q <= 1'b0;
    end else begin
      bclk_oe_q <= act_bm;
      wclk_oe_q <= act_wm;
    end
  end

  acg_sync #(.STAGES(SYNC_STAGES)) u_bsync (
    .clk(clk), .rst(run_rst), .din(bclk_in),
    .level(b_lvl), .rise_nx(b_rise), .fall_nx(b_fall)
  );

  acg_sync #(.STAGES(SYNC_STAGES)) u_wsync (
    .clk(clk), .rst(run_rst), .din(wclk_in),
    .level(w_lvl), .rise_nx(w_rise), .fall_nx(w_fall)
  );

  acg_bclk_gen #(.DIV_W(DIV_W)) u_bclk (
    .clk(clk), .rst(run_rst), .master(act_bm), .div(act_div),
    .sl_rise(b_rise), .sl_fall(b_fall), .rise_nx(rise_nx),
    .bclk_q(bclk_out), .rise_q(bclk_rise), .fall_q(bclk_fall)
  );

  acg_frame_gen #(.LEN_W(LEN_W)) u_frame (
    .clk(clk), .rst(run_rst), .master(act_wm), .shape(wc_shape_e'(act_sq)),
    .len(act_len), .rise_nx(rise_nx), .sl_level(w_lvl),
    .sl_rise(w_rise & ~w_fall), .frame_nx(frame_nx),
    .wclk_q(wclk_out), .fs_q(frame_start)
  );

  assign bclk_oe = bclk_oe_q;
  assign wclk_oe = wclk_oe_q;
endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk (
  input logic clk,
  input logic rst,
  input logic pwr_en,
  input logic bclk_out,
  input logic bclk_oe,
  input logic wclk_out,
  input logic wclk_oe,
  input logic bclk_rise,
  input logic bclk_fall,
  input logic frame_start
);
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(bclk_rise && bclk_fall));

  assert_rise_level_R4: assert property (@(posedge clk) disable iff (rst)
    bclk_rise |-> bclk_out);

  assert_fall_level_R4: assert property (@(posedge clk) disable iff (rst)
    bclk_fall |-> !bclk_out);

  assert_pwrdn_release_R1: assert property (@(posedge clk) disable iff (rst)
    !pwr_en |=> (!bclk_oe && !wclk_oe && !frame_start && !bclk_rise));

  assert_fs_on_rise_R5: assert property (@(posedge clk) disable iff (rst)
    (frame_start && wclk_oe) |-> bclk_rise);

  assert_fs_wclk_high_R6: assert property (@(posedge clk) disable iff (rst)
    (frame_start && wclk_oe) |-> wclk_out);
endmodule

bind audio_clkgen audio_clkgen_chk u_chk (
  .clk(clk), .rst(rst), .pwr_en(pwr_en),
  .bclk_out(bclk_out), .bclk_oe(bclk_oe),
  .wclk_out(wclk_out), .wclk_oe(wclk_oe),
  .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
  .frame_start(frame_start)
);

// File: tb/sim_audio_clkgen.sv
module sim_audio_clkgen;
  localparam int DIV_W = 8;
  localparam int LEN_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_en = 1'b0;
  logic [DIV_W-1:0] cfg_div = 8'd4;
  logic [LEN_W-1:0] cfg_frame_len = 8'd4;
  logic cfg_wc_square = 1'b0;
  logic cfg_bclk_master = 1'b1;
  logic cfg_wclk_master = 1'b1;
  logic bclk_in = 1'b0;
  logic wclk_in = 1'b0;
  logic bclk_out, bclk_oe, wclk_out, wclk_oe, bclk_rise, bclk_fall, frame_start;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit hist [0:511];

  always #10 clk = ~clk;

  audio_clkgen #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst(rst), .pwr_en(pwr_en), .cfg_div(cfg_div),
    .cfg_frame_len(cfg_frame_len), .cfg_wc_square(cfg_wc_square),
    .cfg_bclk_master(cfg_bclk_master), .cfg_wclk_master(cfg_wclk_master),
    .bclk_in(bclk_in), .wclk_in(wclk_in), .bclk_out(bclk_out),
    .bclk_oe(bclk_oe), .wclk_out(wclk_out), .wclk_oe(wclk_oe),
    .bclk_rise(bclk_rise), .bclk_fall(bclk_fall), .frame_start(frame_start)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int clamp2(int v);
    return (v < 2) ? 2 : v;
  endfunction

  function automatic bit hget(int n);
    return (n < 0) ? 1'b0 : hist[n];
  endfunction

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic check_idle(string req);
    check(req, "bclk_oe", int'(bclk_oe), 0);
    check(req, "wclk_oe", int'(wclk_oe), 0);
    check(req, "bclk_out", int'(bclk_out), 0);
    check(req, "wclk_out", int'(wclk_out), 0);
    check(req, "strobes", int'({bclk_rise, bclk_fall, frame_start}), 0);
  endtask

  // power-cycle with new settings; returns at the negedge where pwr_en rises
  task automatic restart(int d, int l, bit sq, bit bm, bit wm);
    @(negedge clk);
    pwr_en = 1'b0;
    cfg_div = DIV_W'(d);
    cfg_frame_len = LEN_W'(l);
    cfg_wc_square = sq;
    cfg_bclk_master = bm;
    cfg_wclk_master = wm;
    @(negedge clk);
    check_idle("R1");
    pwr_en = 1'b1;
  endtask

  // expected master-mode outputs at cycle k after power-up
  task automatic check_master(int k, int d, int l, bit sq, bit clamped);
    int ph = k % d;
    int bi = (k / d) % l;
    string rb = clamped ? "R3" : "R2";
    check(rb, "bclk_out", int'(bclk_out), int'(ph < d / 2));
    check("R4", "bclk_rise", int'(bclk_rise), int'(ph == 0));
    check("R4", "bclk_fall", int'(bclk_fall), int'(ph == d / 2));
    check("R5", "frame_start", int'(frame_start), int'((k % (d * l)) == 0));
    if (sq) check("R6", "wclk_square", int'(wclk_out), int'(bi < l / 2));
    else    check("R7", "wclk_pulse", int'(wclk_out), int'(bi == 0));
    check("R8", "oe_pair", int'({bclk_oe, wclk_oe}), 3);
  endtask

  task automatic run_master(int d, int l, bit sq);
    int dc = clamp2(d);
    int lc = clamp2(l);
    restart(d, l, sq, 1'b1, 1'b1);
    for (int k = 0; k < 2 * dc * lc + 3; k++) begin
      @(negedge clk);
      check_master(k, dc, lc, sq, d < 2 || l < 2);
    end
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst = 1'b0;

    // directed corners
    run_master(2, 2, 1'b1);
    run_master(0, 1, 1'b1);   // R3 and length clamp of R5
    run_master(1, 0, 1'b0);   // R3
    run_master(7, 5, 1'b1);   // R6 odd length rounds down
    run_master(6, 4, 1'b0);   // R7

    // random master settings
    for (int i = 0; i < 8; i++) begin
      run_master(int'($urandom_range(0, 9)), int'($urandom_range(0, 9)), bit'($urandom_range(0, 1)));
    end

    // R10: mid-frame change of divider, length and shape
    restart(4, 4, 1'b1, 1'b1, 1'b1);
    for (int k = 0; k < 16 + 36 + 3; k++) begin
      @(negedge clk);
      if (k < 16) check_master(k, 4, 4, 1'b1, 1'b0);
      else begin
        check("R10", "bclk_new_div", int'(bclk_out), int'(((k - 16) % 3) < 1));
        check_master(k - 16, 3, 6, 1'b0, 1'b0);
      end
      if (k == 5) begin
        cfg_div = 8'd3;
        cfg_frame_len = 8'd6;
        cfg_wc_square = 1'b0;
      end
    end

    // R8: bit clock slave, word clock master pulse of 3
    bclk_in = 1'b0;
    restart(5, 3, 1'b0, 1'b0, 1'b1);
    begin
      int ridx = 0;
      hist[0] = 1'b0;
      bclk_in = 1'b0;
      for (int n = 1; n < 200; n++) begin
        bit er;
        @(negedge clk);
        er = hget(n - 3) & ~hget(n - 4);
        check("R8", "bclk_follow", int'(bclk_out), int'(hget(n - 3)));
        check("R8", "bclk_rise_in", int'(bclk_rise), int'(er));
        check("R8", "bclk_fall_in", int'(bclk_fall), int'(~hget(n - 3) & hget(n - 4)));
        check("R8", "oe_slave_bclk", int'({bclk_oe, wclk_oe}), 1);
        if (er) begin
          check("R8", "fs_count", int'(frame_start), int'((ridx % 3) == 0));
          check("R7", "wclk_counted", int'(wclk_out), int'((ridx % 3) == 0));
          ridx++;
        end else begin
          check("R5", "fs_idle", int'(frame_start), 0);
        end
        hist[n] = ((n % 8) >= 4);
        bclk_in = hist[n];
      end
      check("R8", "rises_seen", int'(ridx > 20), 1);
    end

    // R9: word clock slave, random input pattern
    wclk_in = 1'b0;
    restart(3, 4, 1'b1, 1'b1, 1'b0);
    hist[0] = 1'b0;
    for (int n = 1; n < 200; n++) begin
      @(negedge clk);
      check("R9", "wclk_follow", int'(wclk_out), int'(hget(n - 3)));
      check("R9", "fs_edge", int'(frame_start), int'(hget(n - 3) & ~hget(n - 4)));
      check("R9", "oe_slave_wclk", int'({bclk_oe, wclk_oe}), 2);
      hist[n] = bit'($urandom_range(0, 1));
      wclk_in = hist[n];
    end

    // R1: power down releases lines after a master run
    run_master(3, 3, 1'b1);
    @(negedge clk);
    pwr_en = 1'b0;
    @(negedge clk);
    check_idle("R1");
    @(negedge clk);
    check_idle("R1");

    report();
  end
endmodule